// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This block turns an 8-bit interrupt type code into a new program entry point. When a request arrives, it finds the vector's location in a 1 KiB table at the bottom of memory. It fetches the four vector bytes one at a time over a byte-wide read port, then loads a 16-bit segment and a 16-bit offset into the program-counter pair. Alongside that pair it keeps a registered 20-bit physical fetch address, formed as the segment shifted left by four bits plus the offset.

A core starts the unit with a one-cycle request and waits for the done pulse. In the cycle of that pulse, the segment, the offset and the fetch address all show the new entry point, so the next instruction fetch can use them directly. Out of reset, the pair points at the start location near the top of the address space.

Top module: `ivec_fetch_unit`

## Requirements
- R1: While reset is held and right after it is released, seg_q is FFFFh, off_q is 0000h, fetch_addr is FFFF0h, and busy, done and mem_rd are all 0.
- R2: The first read for type code t goes to address 4*t, so it always falls inside 00000h..003FFh. Type 00h reads 00000h, type 17h reads 0005Ch, type 20h reads 00080h and type FFh reads 003FCh.
- R3: A request produces exactly four single-cycle read strobes, at 4*t, 4*t+1, 4*t+2 and 4*t+3 in that order. A strobe is issued only after the byte for the previous strobe has come back with mem_rvalid.
- R4: The bytes at 4*t and 4*t+1 become off_q, with the lower address in bits 7:0. The bytes at 4*t+2 and 4*t+3 become seg_q in the same way. Bytes 10h,20h,30h,40h give seg_q 4030h and off_q 2010h. Bytes 90h,78h,40h,23h give 2340h:7890h.
- R5: fetch_addr always equals (seg_q*16 + off_q) mod 2^20, and it takes its new value in the same cycle as seg_q and off_q. Bytes 06h,30h,00h,40h give 43006h.
- R6: The addition wraps. Segment FFFFh with offset 0010h gives fetch_addr 00000h.
- R7: busy is 1 from the cycle after a request is accepted until the last byte is taken. done is a one-cycle pulse in the first cycle that shows the new seg_q/off_q, and busy is 0 in that cycle.
- R8: A request that arrives while busy is 1 is ignored. It starts no read and has no effect on the loaded values.
- R9: A mem_rvalid that arrives while no read is outstanding is ignored. seg_q, off_q and fetch_addr stay the same and no read starts.
- R10: seg_q and off_q change only in a cycle where done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_valid | input | 1 | One-cycle interrupt request |
| irq_type | input | 8 | Interrupt type code, sampled with irq_valid |
| busy | output | 1 | Vector fetch in progress |
| done | output | 1 | One-cycle pulse when the new entry point is loaded |
| mem_rd | output | 1 | One-cycle byte read strobe |
| mem_addr | output | 20 | Byte read address |
| mem_rvalid | input | 1 | Returned byte is valid |
| mem_rdata | input | 8 | Returned byte |
| seg_q | output | 16 | Segment half of the program counter |
| off_q | output | 16 | Offset half of the program counter |
| fetch_addr | output | 20 | Physical instruction fetch address |

## Verification
The assertions assume that the memory raises mem_rvalid for one cycle per strobe, at least one cycle after the strobe and before the next strobe. They also assume that irq_type is stable whenever irq_valid is sampled. The bench memory model replies with a rotating latency of one to three cycles and drops mem_rvalid after one cycle. Its stray mem_rvalid pulse and its request during a fetch are the only deliberate breaks in the handshake, and both fall in windows where the design must ignore them. The checks that expect no effect then look at the read strobes, the read counter and the loaded pair at the ports.

// File: rtl/ivf_pkg.sv
package ivf_pkg;
  typedef enum logic {SQ_IDLE = 1'b0, SQ_WAIT = 1'b1} seq_state_e;
endpackage

// File: rtl/ivf_byte_seq.sv
module ivf_byte_seq
  import ivf_pkg::*;
#(
  parameter int TYPE_W     = 8,
  parameter int ADDR_W     = 20,
  parameter int VEC_BYTES  = 4,
  parameter int TABLE_BASE = 0,
  localparam int IDX_W     = (VEC_BYTES > 1) ? $clog2(VEC_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [TYPE_W-1:0] req_type,
  input  logic              mem_rvalid,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              beat_valid,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              last_beat
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(VEC_BYTES - 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic              busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      rd_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (req_valid) begin
            addr_q  <= ADDR_W'(TABLE_BASE) + ADDR_W'(req_type) * ADDR_W'(VEC_BYTES);
            idx_q   <= '0;
            rd_q    <= 1'b1;
            busy_q  <= 1'b1;
            state_q <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (mem_rvalid) begin
            if (idx_q == LAST_IDX) begin
              busy_q  <= 1'b0;
              state_q <= SQ_IDLE;
            end else begin
              idx_q  <= idx_q + 1'b1;
              addr_q <= addr_q + 1'b1;
              rd_q   <= 1'b1;
            end
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign mem_rd     = rd_q;
  assign mem_addr   = addr_q;
  assign busy       = busy_q;
  assign beat_valid = (state_q == SQ_WAIT) && mem_rvalid;
  assign beat_idx   = idx_q;
  assign last_beat  = beat_valid && (idx_q == LAST_IDX);
endmodule

// File: rtl/ivf_vec_collect.sv
module ivf_vec_collect #(
  parameter int DATA_W    = 8,
  parameter int VEC_BYTES = 4,
  parameter int REG_W     = 16,
  localparam int IDX_W    = (VEC_BYTES > 1) ? $clog2(VEC_BYTES) : 1,
  localparam int VEC_W    = VEC_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_valid,
  input  logic [IDX_W-1:0]  beat_idx,
  input  logic [DATA_W-1:0] beat_data,
  input  logic              last_beat,
  output logic [REG_W-1:0]  off_d,
  output logic [REG_W-1:0]  seg_d,
  output logic              load
);
  logic [VEC_W-1:0] vec_w;

  // Earlier bytes wait in lanes; the final byte is used straight from the port.
  for (genvar g = 0; g < VEC_BYTES - 1; g++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst) lane_q <= '0;
      else if (beat_valid && beat_idx == IDX_W'(g)) lane_q <= beat_data;
    end
    assign vec_w[g*DATA_W +: DATA_W] = lane_q;
  end
  assign vec_w[VEC_W-1 -: DATA_W] = beat_data;

  assign off_d = vec_w[REG_W-1:0];
  assign seg_d = vec_w[2*REG_W-1:REG_W];
  assign load  = last_beat;
endmodule

// File: rtl/ivf_phys_addr.sv
module ivf_phys_addr #(
  parameter int REG_W     = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic [REG_W-1:0]  seg,
  input  logic [REG_W-1:0]  off,
  output logic [ADDR_W-1:0] phys
);
  logic [ADDR_W-1:0] seg_sh;
  assign seg_sh = ADDR_W'({seg, {SEG_SHIFT{1'b0}}});
  assign phys   = seg_sh + ADDR_W'(off);
endmodule

// File: rtl/ivf_pc_regs.sv
module ivf_pc_regs #(
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 20,
  parameter logic [REG_W-1:0]  RESET_SEG   = '1,
  parameter logic [REG_W-1:0]  RESET_OFF   = '0,
  parameter logic [ADDR_W-1:0] RESET_FETCH = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [REG_W-1:0]  seg_d,
  input  logic [REG_W-1:0]  off_d,
  input  logic [ADDR_W-1:0] phys_d,
  output logic [REG_W-1:0]  seg_q,
  output logic [REG_W-1:0]  off_q,
  output logic [ADDR_W-1:0] fetch_q,
  output logic              done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q   <= RESET_SEG;
      off_q   <= RESET_OFF;
      fetch_q <= RESET_FETCH;
      done_q  <= 1'b0;
    end else begin
      done_q <= load;
      if (load) begin
        seg_q   <= seg_d;
        off_q   <= off_d;
        fetch_q <= phys_d;
      end
    end
  end
endmodule

// File: rtl/ivec_fetch_unit.sv
module ivec_fetch_unit #(
  parameter int TYPE_W     = 8,
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 8,
  parameter int REG_W      = 16,
  parameter int VEC_BYTES  = 4,
  parameter int SEG_SHIFT  = 4,
  parameter int TABLE_BASE = 0,
  parameter int RESET_SEG  = 'hFFFF,
  parameter int RESET_OFF  = 0,
  localparam int IDX_W     = (VEC_BYTES > 1) ? $clog2(VEC_BYTES) : 1,
  localparam logic [ADDR_W-1:0] RESET_FETCH =
    ADDR_W'((RESET_SEG << SEG_SHIFT) + RESET_OFF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_valid,
  input  logic [TYPE_W-1:0] irq_type,
  output logic              busy,
  output logic              done,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [REG_W-1:0]  seg_q,
  output logic [REG_W-1:0]  off_q,
  output logic [ADDR_W-1:0] fetch_addr
);
  logic             beat_valid, last_beat, load;
  logic [IDX_W-1:0] beat_idx;
  logic [REG_W-1:0] seg_d, off_d;
  logic [ADDR_W-1:0] phys_d;

  ivf_byte_seq #(
    .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES), .TABLE_BASE(TABLE_BASE)
  ) seq_i (
    .clk(clk), .rst(rst), .req_valid(irq_valid), .req_type(irq_type),
    .mem_rvalid(mem_rvalid), .mem_rd(mem_rd), .mem_addr(mem_addr), .busy(busy),
    .beat_valid(beat_valid), .beat_idx(beat_idx), .last_beat(last_beat)
  );

  ivf_vec_collect #(
    .DATA_W(DATA_W), .VEC_BYTES(VEC_BYTES), .REG_W(REG_W)
  ) collect_i (
    .clk(clk), .rst(rst), .beat_valid(beat_valid), .beat_idx(beat_idx),
    .beat_data(mem_rdata), .last_beat(last_beat),
    .off_d(off_d), .seg_d(seg_d), .load(load)
  );

  // The adder works on the incoming pair, so the address registers with it.
  ivf_phys_addr #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)
  ) adder_i (
    .seg(seg_d), .off(off_d), .phys(phys_d)
  );

  ivf_pc_regs #(
    .REG_W(REG_W), .ADDR_W(ADDR_W),
    .RESET_SEG(REG_W'(RESET_SEG)), .RESET_OFF(REG_W'(RESET_OFF)),
    .RESET_FETCH(RESET_FETCH)
  ) regs_i (
    .clk(clk), .rst(rst), .load(load), .seg_d(seg_d), .off_d(off_d),
    .phys_d(phys_d), .seg_q(seg_q), .off_q(off_q), .fetch_q(fetch_addr),
    .done_q(done)
  );
endmodule

// File: rtl/ivf_chk.sv
module ivf_chk #(
  parameter int TYPE_W     = 8,
  parameter int ADDR_W     = 20,
  parameter int REG_W      = 16,
  parameter int VEC_BYTES  = 4,
  parameter int SEG_SHIFT  = 4,
  parameter int TABLE_BASE = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [TYPE_W-1:0] irq_type,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [REG_W-1:0]  seg_q,
  input logic [REG_W-1:0]  off_q,
  input logic [ADDR_W-1:0] fetch_addr
);
  localparam logic [ADDR_W-1:0] TABLE_END =
    ADDR_W'(TABLE_BASE + (2 ** TYPE_W) * VEC_BYTES);

  // R2
  rd_base_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mem_rd &&
      mem_addr == ADDR_W'(TABLE_BASE) + ADDR_W'($past(irq_type)) * ADDR_W'(VEC_BYTES));

  // R2
  rd_in_table_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr >= ADDR_W'(TABLE_BASE)) && (mem_addr < TABLE_END));

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R3
  rd_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  // R5
  fetch_match_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_addr == ADDR_W'({seg_q, {SEG_SHIFT{1'b0}}}) + ADDR_W'(off_q));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(seg_q) && $stable(off_q));
endmodule

bind ivec_fetch_unit ivf_chk chk_i (
  .clk(clk), .rst(rst), .irq_type(irq_type), .busy(busy), .done(done),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .seg_q(seg_q), .off_q(off_q),
  .fetch_addr(fetch_addr)
);

// File: tb/ivec_fetch_unit_tb_top.sv
module ivec_fetch_unit_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, irq_valid, busy, done, mem_rd, mem_rvalid;
  logic [7:0]  irq_type, mem_rdata;
  logic [19:0] mem_addr, fetch_addr;
  logic [15:0] seg_q, off_q;

  logic       resp_rv = 1'b0, stray_rv = 1'b0;
  logic [7:0] resp_data = 8'h00, stray_data = 8'h00;
  assign mem_rvalid = resp_rv | stray_rv;
  assign mem_rdata  = stray_rv ? stray_data : resp_data;

  ivec_fetch_unit dut_i (
    .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_type(irq_type),
    .busy(busy), .done(done), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .seg_q(seg_q),
    .off_q(off_q), .fetch_addr(fetch_addr)
  );

  logic [7:0] tbl [0:1023];

  typedef struct {
    logic [15:0] seg;
    logic [15:0] off;
    logic [19:0] fa;
  } res_t;

  logic [19:0] exp_addr_q [$];
  res_t        exp_res_q  [$];
  int checks = 0, errors = 0, rd_count = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory responder: rotating latency, one-cycle rvalid.
  initial begin
    int lat = 0;
    logic [19:0] a;
    forever begin
      if (mem_rd === 1'b1) begin
        a = mem_addr;
        repeat (1 + lat) @(negedge clk);
        resp_data = tbl[a[9:0]];
        resp_rv   = 1'b1;
        @(negedge clk);
        resp_rv = 1'b0;
        lat = (lat + 1) % 3;
      end else begin
        @(negedge clk);
      end
    end
  end

  // Monitor: pops expected items as the design produces them.
  initial begin
    logic [19:0] ea;
    res_t er;
    forever begin
      @(negedge clk);
      if (rst === 1'b0) begin
        if (mem_rd === 1'b1) begin
          rd_count++;
          if (exp_addr_q.size() == 0) chk(1'b0, "R8 unexpected read", {12'h0, mem_addr}, 32'h0);
          else begin
            ea = exp_addr_q.pop_front();
            chk(mem_addr === ea, "R3 read address order", {12'h0, mem_addr}, {12'h0, ea});
          end
        end
        if (done === 1'b1) begin
          if (exp_res_q.size() == 0) chk(1'b0, "R7 unexpected done", 32'h1, 32'h0);
          else begin
            er = exp_res_q.pop_front();
            chk(seg_q === er.seg, "R4 segment", {16'h0, seg_q}, {16'h0, er.seg});
            chk(off_q === er.off, "R4 offset", {16'h0, off_q}, {16'h0, er.off});
            chk(fetch_addr === er.fa, "R5 fetch address", {12'h0, fetch_addr}, {12'h0, er.fa});
            chk(busy === 1'b0, "R7 busy low at done", {31'h0, busy}, 32'h0);
          end
        end
      end
    end
  end

  // Driver: pushes the expected reads and result, then raises the request.
  task automatic send_irq(input logic [7:0] t, input bit inject);
    logic [19:0] b;
    res_t r;
    bit seen = 1'b0;
    b = {10'h0, t, 2'b00};
    for (int k = 0; k < 4; k++) exp_addr_q.push_back(b + 20'(k));
    r.off = {tbl[b[9:0] + 10'd1], tbl[b[9:0]]};
    r.seg = {tbl[b[9:0] + 10'd3], tbl[b[9:0] + 10'd2]};
    r.fa  = {r.seg, 4'h0} + {4'h0, r.off};
    exp_res_q.push_back(r);
    @(negedge clk);
    irq_valid = 1'b1;
    irq_type  = t;
    @(negedge clk);
    irq_valid = 1'b0;
    chk(busy === 1'b1, "R7 busy after accept", {31'h0, busy}, 32'h1);
    if (inject) begin
      @(negedge clk);
      irq_valid = 1'b1;
      irq_type  = t ^ 8'h5A;
      @(negedge clk);
      irq_valid = 1'b0;
    end
    for (int w = 0; w < 40 && !seen; w++) begin
      if (done === 1'b1) seen = 1'b1;
      else @(negedge clk);
    end
    chk(seen, "R7 done pulse seen", {31'h0, seen}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rc;
    logic [15:0] hs, ho;
    for (int i = 0; i < 1024; i++) tbl[i] = 8'((i * 37 + 11) ^ (i >> 3));
    tbl[10'h080] = 8'h10; tbl[10'h081] = 8'h20; tbl[10'h082] = 8'h30; tbl[10'h083] = 8'h40;
    tbl[10'h084] = 8'h06; tbl[10'h085] = 8'h30; tbl[10'h086] = 8'h00; tbl[10'h087] = 8'h40;
    tbl[10'h05C] = 8'h90; tbl[10'h05D] = 8'h78; tbl[10'h05E] = 8'h40; tbl[10'h05F] = 8'h23;
    tbl[10'h100] = 8'h10; tbl[10'h101] = 8'h00; tbl[10'h102] = 8'hFF; tbl[10'h103] = 8'hFF;
    rst = 1'b1; irq_valid = 1'b0; irq_type = 8'h00;
    repeat (3) @(negedge clk);
    chk(seg_q === 16'hFFFF, "R1 reset segment", {16'h0, seg_q}, 32'hFFFF);
    rst = 1'b0;
    chk(off_q === 16'h0000, "R1 reset offset", {16'h0, off_q}, 32'h0);
    chk(fetch_addr === 20'hFFFF0, "R1 reset fetch", {12'h0, fetch_addr}, 32'hFFFF0);
    chk(busy === 1'b0 && done === 1'b0 && mem_rd === 1'b0, "R1 reset flags",
        {29'h0, busy, done, mem_rd}, 32'h0);

    send_irq(8'h20, 1'b0);
    chk(seg_q === 16'h4030 && off_q === 16'h2010, "R4 type 20h entry", {seg_q, off_q}, 32'h40302010);
    send_irq(8'h21, 1'b0);
    chk(fetch_addr === 20'h43006, "R5 fetch 43006h", {12'h0, fetch_addr}, 32'h43006);
    send_irq(8'h17, 1'b0);
    chk(seg_q === 16'h2340 && off_q === 16'h7890, "R4 type 17h entry", {seg_q, off_q}, 32'h23407890);
    chk(fetch_addr === 20'h2AC90, "R5 fetch 2AC90h", {12'h0, fetch_addr}, 32'h2AC90);
    send_irq(8'h40, 1'b0);
    chk(fetch_addr === 20'h00000, "R6 wrap to zero", {12'h0, fetch_addr}, 32'h0);
    send_irq(8'h00, 1'b0);
    send_irq(8'hFF, 1'b0);
    chk(exp_addr_q.size() == 0, "R2 all table reads issued", exp_addr_q.size(), 32'h0);

    // R8: a second request during the fetch must not start anything.
    rc = rd_count;
    send_irq(8'h05, 1'b1);
    hs = seg_q; ho = off_q;
    repeat (8) @(negedge clk);
    chk(rd_count - rc == 4, "R8 only four reads", rd_count - rc, 32'd4);
    chk(seg_q === hs && off_q === ho, "R10 pair held after done", {seg_q, off_q}, {hs, ho});

    // R9: a stray byte while idle is ignored.
    rc = rd_count;
    stray_data = 8'hAA;
    stray_rv = 1'b1;
    @(negedge clk);
    stray_rv = 1'b0;
    repeat (4) @(negedge clk);
    chk(seg_q === hs && off_q === ho, "R9 stray byte ignored", {seg_q, off_q}, {hs, ho});
    chk(rd_count == rc && busy === 1'b0, "R9 no read after stray byte", rd_count - rc, 32'h0);

    send_irq(8'h20, 1'b0);
    chk(seg_q === 16'h4030 && off_q === 16'h2010, "R4 fetch after stray byte", {seg_q, off_q}, 32'h40302010);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule